// File: doc/BRIEF.md
# Low-Power Mode Wake-Up Controller

This block sequences the operating mode of a small microcontroller-style system. It knows seven modes: normal-high, normal-low, doze-high, doze-low, sleep, deep-sleep and power-down. It decides on every clock edge whether to stay in the current mode or move to another. Its inputs are a level-sensitive interrupt-pending line, timer event pulses, software mode requests, a power-management enable, a gear-switching enable and divider configuration. It produces a one-hot mode vector, a registered gear select with the divider value that goes with it, and a one-cycle strobe when a wake-up completes.

The block does not make clocks, drive a PLL or switch supplies. It models the time a wake-up takes with a shared latency counter. A wake from normal-low, doze or sleep takes a fixed few cycles. A wake from deep-sleep takes a configurable count, capped at 499. Leaving power-down uses a request/acknowledge handshake with an external supply controller and ends with a power-on-sequence strobe.

When gear switching is enabled and nothing asynchronous is pending, the controller drops normal-high to normal-low, and doze-high to doze-low, on its own. Any timer event sets a sticky status flag. Software clears that flag with a write-one-to-clear strobe. While the flag is set, it counts as a pending asynchronous interrupt.

Top module: `lpw_mode_ctrl`

## Requirements
- R1: During and after synchronous reset the mode is normal-high, `gear_hi` is 1, `div_sel` equals `div_hi_cfg`, and `wake_done`, `pwr_req`, `por_req` and `tmr_flag` are 0.
- R2: `mode_oh` always has exactly one bit set. Bit 0 is normal-high, bit 1 normal-low, bit 2 doze-high, bit 3 doze-low, bit 4 sleep, bit 5 deep-sleep and bit 6 power-down. Every change of mode takes effect on one clock edge.
- R3: In normal-high, when `gear_en` is 1, `irq_pend` is 0 and `tmr_flag` is 0, and no request is accepted, the mode becomes normal-low on the next edge. On that same edge `gear_hi` becomes 0 and `div_sel` becomes `div_lo_cfg`. Doze-high drops to doze-low under the same gear conditions.
- R4: Normal-low starts a wake-up when `irq_pend`, `tmr_flag` or the inverse of `gear_en` is 1. The mode becomes normal-high FAST_LAT (default 3) edges after the edge that saw the condition. `wake_done` is 1 for exactly the cycle in which the new mode first shows.
- R5: A request (`req_valid`=1) is accepted only in normal-high or normal-low. The codes on `req_code` are: 1 doze, 2 sleep, 3 deep-sleep, 4 power-down. Any other code is ignored, and so is any request made in a low-power mode. A doze request enters doze-high from normal-high and doze-low from normal-low.
- R6: Doze-high or doze-low wakes to normal-high FAST_LAT edges after `irq_pend` is seen. Doze-low moves up to doze-high on one edge when `tmr_flag` is 1 or `gear_en` is 0.
- R7: Sleep wakes to normal-high FAST_LAT edges after `irq_pend` or `tmr_flag` is seen.
- R8: Deep-sleep wakes to normal-high when `irq_pend` is 1 or `pm_en` is 0. The wake takes L edges, where L is `dsl_cfg`, except that 0 counts as 1 and values above 499 count as 499.
- R9: In power-down, `irq_pend` and `pwr_good` alone have no effect. `ext_wake` sets `pwr_req` on the next edge. `pwr_good` while `pwr_req` is 1 moves the mode to normal-high, clears `pwr_req`, and pulses both `por_req` and `wake_done` for one cycle.
- R10: Any bit of `tmr_evt` sets `tmr_flag` on the next edge. `tmr_flag` clears only on an edge with `tmr_clr` high and no event, so an event wins when both arrive together.
- R11: A request for any low-power mode is rejected, and the normal mode held, while `tmr_flag` is 1 or `pm_en` is 0.
- R12: `irq_pend` is treated as a level. While it stays high in normal-high, no gear-down happens. A wake-up that has started completes even if `irq_pend` falls during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pend | input | 1 | Level interrupt pending from the interrupt controller |
| tmr_evt | input | NTMR | Timer event pulses (real-time clock, periodic, time base, decrementer) |
| tmr_clr | input | 1 | Write-one-to-clear strobe for the timer status flag |
| pm_en | input | 1 | Power-management enable |
| gear_en | input | 1 | Automatic gear-switching enable |
| div_hi_cfg | input | DIVW | Divider setting for high gear |
| div_lo_cfg | input | DIVW | Divider setting for low gear |
| dsl_cfg | input | CW | Deep-sleep wake latency in cycles |
| req_valid | input | 1 | Software mode request strobe |
| req_code | input | 3 | Requested low-power mode code |
| ext_wake | input | 1 | External wake request for power-down |
| pwr_good | input | 1 | Supply acknowledge from the power controller |
| mode_oh | output | 7 | One-hot current mode |
| gear_hi | output | 1 | 1 = high-frequency gear |
| div_sel | output | DIVW | Active divider value |
| wake_done | output | 1 | One-cycle strobe when normal-high is reached from a wake |
| pwr_req | output | 1 | Supply power-up request |
| por_req | output | 1 | Power-on-sequence request strobe |
| tmr_flag | output | 1 | Sticky timer status flag |

## Verification
A corrupted mode register shows at once on `mode_oh`, either as a wrong bit or as a vector that is not one-hot, and a gear bit that disagrees with it shows on `div_sel` in the same cycle. A latency counter that loads or decrements wrongly shows as a `wake_done` strobe one or more cycles off the expected edge: three edges after the wake condition for the fast wakes, and the clamped count after it for deep-sleep. A lost or spurious timer flag shows on `tmr_flag` one edge after the event or clear, and one edge later as a request that is wrongly accepted or rejected.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  localparam int NMODE = 7;

  localparam int BIT_NH = 0;
  localparam int BIT_NL = 1;
  localparam int BIT_DH = 2;
  localparam int BIT_DL = 3;
  localparam int BIT_SL = 4;
  localparam int BIT_DS = 5;
  localparam int BIT_PD = 6;

  typedef logic [NMODE-1:0] mode_t;

  localparam mode_t M_NH = mode_t'(1 << BIT_NH);
  localparam mode_t M_NL = mode_t'(1 << BIT_NL);
  localparam mode_t M_DH = mode_t'(1 << BIT_DH);
  localparam mode_t M_DL = mode_t'(1 << BIT_DL);
  localparam mode_t M_SL = mode_t'(1 << BIT_SL);
  localparam mode_t M_DS = mode_t'(1 << BIT_DS);
  localparam mode_t M_PD = mode_t'(1 << BIT_PD);

  typedef enum logic [2:0] {
    RQ_NONE  = 3'd0,
    RQ_DOZE  = 3'd1,
    RQ_SLEEP = 3'd2,
    RQ_DEEP  = 3'd3,
    RQ_PDOWN = 3'd4
  } req_e;

  // True when a mode vector has the high-frequency gear.
  function automatic logic mode_is_high(input mode_t m);
    return m[BIT_NH] | m[BIT_DH];
  endfunction
endpackage

// File: rtl/lpw_tmr_flag.sv
module lpw_tmr_flag #(
  parameter int NTMR = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NTMR-1:0] evt,
  input  logic            clr,
  output logic            flag
);
  logic any_evt;

  always_comb begin
    any_evt = 1'b0;
    for (int i = 0; i < NTMR; i++) any_evt = any_evt | evt[i];
  end

  // A new event outranks a simultaneous clear.
  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (any_evt) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end
endmodule

// File: rtl/lpw_lat_cnt.sv
module lpw_lat_cnt #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] lat_val,
  output logic          busy,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  assign expire = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= lat_val - CW'(1);
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/lpw_gear_out.sv
module lpw_gear_out #(
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hi_nx,
  input  logic [DIVW-1:0] div_hi,
  input  logic [DIVW-1:0] div_lo,
  output logic            gear_hi,
  output logic [DIVW-1:0] div_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gear_hi <= 1'b1;
      div_sel <= div_hi;
    end else begin
      gear_hi <= hi_nx;
      div_sel <= hi_nx ? div_hi : div_lo;
    end
  end
endmodule

// File: rtl/lpw_mode_fsm.sv
module lpw_mode_fsm
  import lpw_pkg::*;
#(
  parameter int CW       = 9,
  parameter int FAST_LAT = 3,
  parameter int DEEP_MAX = 499
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_pend,
  input  logic          flag,
  input  logic          pm_en,
  input  logic          gear_en,
  input  logic [CW-1:0] dsl_cfg,
  input  logic          req_valid,
  input  logic [2:0]    req_code,
  input  logic          ext_wake,
  input  logic          pwr_good,
  input  logic          busy,
  input  logic          expire,
  output logic          start,
  output logic [CW-1:0] lat_val,
  output mode_t         mode_q,
  output mode_t         mode_nx,
  output logic          wake_done,
  output logic          pwr_req,
  output logic          por_req
);
  logic          req_ok;
  logic          code_ok;
  logic          pwr_nx;
  logic          done_nx;
  logic          por_nx;
  logic [CW-1:0] deep_eff;

  // Deep-sleep latency: zero means one cycle, values above the cap saturate.
  always_comb begin
    if (dsl_cfg == '0)                 deep_eff = CW'(1);
    else if (dsl_cfg > CW'(DEEP_MAX))  deep_eff = CW'(DEEP_MAX);
    else                               deep_eff = dsl_cfg;
  end

  assign lat_val = (mode_q == M_DS) ? deep_eff : CW'(FAST_LAT);
  assign code_ok = (req_code >= RQ_DOZE) && (req_code <= RQ_PDOWN);
  assign req_ok  = req_valid && code_ok && pm_en && !flag && !busy;

  function automatic mode_t req_target(input logic [2:0] code, input logic from_hi);
    case (code)
      RQ_DOZE:  return from_hi ? M_DH : M_DL;
      RQ_SLEEP: return M_SL;
      RQ_DEEP:  return M_DS;
      default:  return M_PD;
    endcase
  endfunction

  always_comb begin
    mode_nx = mode_q;
    start   = 1'b0;
    pwr_nx  = pwr_req;
    done_nx = 1'b0;
    por_nx  = 1'b0;
    if (expire) begin
      mode_nx = M_NH;
      done_nx = 1'b1;
    end else if (!busy) begin
      case (mode_q)
        M_NH: begin
          if (req_ok)                              mode_nx = req_target(req_code, 1'b1);
          else if (gear_en && !irq_pend && !flag)  mode_nx = M_NL;
        end
        M_NL: begin
          if (irq_pend || flag || !gear_en)        start   = 1'b1;
          else if (req_ok)                         mode_nx = req_target(req_code, 1'b0);
        end
        M_DH: begin
          if (irq_pend)                            start   = 1'b1;
          else if (gear_en && !flag)               mode_nx = M_DL;
        end
        M_DL: begin
          if (irq_pend)                            start   = 1'b1;
          else if (flag || !gear_en)               mode_nx = M_DH;
        end
        M_SL: begin
          if (irq_pend || flag)                    start   = 1'b1;
        end
        M_DS: begin
          if (irq_pend || !pm_en)                  start   = 1'b1;
        end
        M_PD: begin
          if (pwr_req && pwr_good) begin
            mode_nx = M_NH;
            pwr_nx  = 1'b0;
            por_nx  = 1'b1;
            done_nx = 1'b1;
          end else if (ext_wake) begin
            pwr_nx  = 1'b1;
          end
        end
        default: mode_nx = M_NH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= M_NH;
      wake_done <= 1'b0;
      pwr_req   <= 1'b0;
      por_req   <= 1'b0;
    end else begin
      mode_q    <= mode_nx;
      wake_done <= done_nx;
      pwr_req   <= pwr_nx;
      por_req   <= por_nx;
    end
  end
endmodule

// File: rtl/lpw_mode_ctrl.sv
module lpw_mode_ctrl
  import lpw_pkg::*;
#(
  parameter int NTMR     = 4,
  parameter int DIVW     = 4,
  parameter int FAST_LAT = 3,
  parameter int DEEP_MAX = 499,
  localparam int CW      = $clog2(DEEP_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            irq_pend,
  input  logic [NTMR-1:0] tmr_evt,
  input  logic            tmr_clr,
  input  logic            pm_en,
  input  logic            gear_en,
  input  logic [DIVW-1:0] div_hi_cfg,
  input  logic [DIVW-1:0] div_lo_cfg,
  input  logic [CW-1:0]   dsl_cfg,
  input  logic            req_valid,
  input  logic [2:0]      req_code,
  input  logic            ext_wake,
  input  logic            pwr_good,
  output logic [NMODE-1:0] mode_oh,
  output logic            gear_hi,
  output logic [DIVW-1:0] div_sel,
  output logic            wake_done,
  output logic            pwr_req,
  output logic            por_req,
  output logic            tmr_flag
);
  logic          start;
  logic          busy;
  logic          expire;
  logic [CW-1:0] lat_val;
  mode_t         mode_q;
  mode_t         mode_nx;

  lpw_tmr_flag #(.NTMR(NTMR)) flag_i (
    .clk (clk), .rst (rst), .evt (tmr_evt), .clr (tmr_clr), .flag (tmr_flag)
  );

  lpw_lat_cnt #(.CW(CW)) lat_i (
    .clk (clk), .rst (rst), .start (start), .lat_val (lat_val),
    .busy (busy), .expire (expire)
  );

  lpw_mode_fsm #(.CW(CW), .FAST_LAT(FAST_LAT), .DEEP_MAX(DEEP_MAX)) fsm_i (
    .clk (clk), .rst (rst), .irq_pend (irq_pend), .flag (tmr_flag),
    .pm_en (pm_en), .gear_en (gear_en), .dsl_cfg (dsl_cfg),
    .req_valid (req_valid), .req_code (req_code), .ext_wake (ext_wake),
    .pwr_good (pwr_good), .busy (busy), .expire (expire), .start (start),
    .lat_val (lat_val), .mode_q (mode_q), .mode_nx (mode_nx),
    .wake_done (wake_done), .pwr_req (pwr_req), .por_req (por_req)
  );

  lpw_gear_out #(.DIVW(DIVW)) gear_i (
    .clk (clk), .rst (rst), .hi_nx (mode_is_high(mode_nx)),
    .div_hi (div_hi_cfg), .div_lo (div_lo_cfg),
    .gear_hi (gear_hi), .div_sel (div_sel)
  );

  assign mode_oh = mode_q;
endmodule

// File: rtl/lpw_mode_ctrl_chk.sv
module lpw_mode_ctrl_chk
  import lpw_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [NMODE-1:0] mode_oh,
  input logic             tmr_flag,
  input logic             tmr_clr,
  input logic             wake_done,
  input logic             por_req,
  input logic             pwr_req,
  input logic             pwr_good
);
  AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(mode_oh) == 1); // R2

  AST_DONE_IN_NH: assert property (@(posedge clk) disable iff (rst)
    wake_done |-> mode_oh[BIT_NH]); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tmr_flag && !tmr_clr) |=> tmr_flag); // R10

  AST_REJECT_LP: assert property (@(posedge clk) disable iff (rst)
    ((mode_oh[BIT_NH] || mode_oh[BIT_NL]) && tmr_flag) |=> (mode_oh[BIT_NH] || mode_oh[BIT_NL])); // R11

  AST_PD_EXIT: assert property (@(posedge clk) disable iff (rst)
    mode_oh[BIT_PD] |=> (mode_oh[BIT_PD] || mode_oh[BIT_NH])); // R9

  AST_POR_ACK: assert property (@(posedge clk) disable iff (rst)
    por_req |-> $past(pwr_req && pwr_good)); // R9
endmodule

bind lpw_mode_ctrl lpw_mode_ctrl_chk chk_i (
  .clk (clk), .rst (rst), .mode_oh (mode_oh), .tmr_flag (tmr_flag),
  .tmr_clr (tmr_clr), .wake_done (wake_done), .por_req (por_req),
  .pwr_req (pwr_req), .pwr_good (pwr_good)
);

// File: tb/lpw_mode_ctrl_tb.sv
module lpw_mode_ctrl_tb_top;
  localparam int NTMR = 4;
  localparam int DIVW = 4;
  localparam int CW   = 9;

  localparam logic [6:0] NH = 7'h01, NL = 7'h02, DH = 7'h04, DL = 7'h08,
                         SL = 7'h10, DS = 7'h20, PD = 7'h40;

  logic            clk = 1'b0;
  logic            rst;
  logic            irq_pend, tmr_clr, pm_en, gear_en, req_valid, ext_wake, pwr_good;
  logic [NTMR-1:0] tmr_evt;
  logic [DIVW-1:0] div_hi_cfg, div_lo_cfg;
  logic [CW-1:0]   dsl_cfg;
  logic [2:0]      req_code;
  logic [6:0]      mode_oh;
  logic            gear_hi, wake_done, pwr_req, por_req, tmr_flag;
  logic [DIVW-1:0] div_sel;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lpw_mode_ctrl dut_i (
    .clk (clk), .rst (rst), .irq_pend (irq_pend), .tmr_evt (tmr_evt),
    .tmr_clr (tmr_clr), .pm_en (pm_en), .gear_en (gear_en),
    .div_hi_cfg (div_hi_cfg), .div_lo_cfg (div_lo_cfg), .dsl_cfg (dsl_cfg),
    .req_valid (req_valid), .req_code (req_code), .ext_wake (ext_wake),
    .pwr_good (pwr_good), .mode_oh (mode_oh), .gear_hi (gear_hi),
    .div_sel (div_sel), .wake_done (wake_done), .pwr_req (pwr_req),
    .por_req (por_req), .tmr_flag (tmr_flag)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; irq_pend = 0; tmr_evt = '0; tmr_clr = 0; pm_en = 1;
    gear_en = 0; div_hi_cfg = 4'h1; div_lo_cfg = 4'h8; dsl_cfg = 9'd10;
    req_valid = 0; req_code = 3'd0; ext_wake = 0; pwr_good = 0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic request(input logic [2:0] code);
    req_valid = 1; req_code = code;
    tick();
    req_valid = 0; req_code = 3'd0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 mode", mode_oh, NH);
    chk("R1 gear_hi", gear_hi, 1);
    chk("R1 div_sel", div_sel, 4'h1);
    chk("R1 strobes", {wake_done, pwr_req, por_req, tmr_flag}, 0);
  endtask

  task automatic t_gear_and_nl_wake();
    do_reset();
    gear_en = 1; tick();
    chk("R3 gear-down mode", mode_oh, NL);
    chk("R3 gear_hi low", gear_hi, 0);
    chk("R3 div_sel low", div_sel, 4'h8);
    irq_pend = 1; tick(); tick(); tick();
    chk("R4 still low before latency", mode_oh, NL);
    chk("R4 no early done", wake_done, 0);
    tick();
    chk("R4 woke to high", mode_oh, NH);
    chk("R4 done strobe", wake_done, 1);
    chk("R2 div_sel high", div_sel, 4'h1);
    tick();
    chk("R4 done one cycle", wake_done, 0);
    chk("R12 level irq blocks gear-down", mode_oh, NH);
    irq_pend = 0; tick();
    chk("R3 back to low", mode_oh, NL);
    irq_pend = 1; tick(); irq_pend = 0; tick(); tick();
    chk("R12 wake in progress", mode_oh, NL);
    tick();
    chk("R12 wake completes after irq drop", {mode_oh, wake_done}, {NH, 1'b1});
    gear_en = 0; tick();
    chk("R3 no gear-down when disabled", mode_oh, NH);
  endtask

  task automatic t_flag_and_reject();
    do_reset();
    tmr_evt = 4'b0100; tick(); tmr_evt = '0;
    chk("R10 flag set", tmr_flag, 1);
    request(3'd2);
    chk("R11 sleep rejected while flag", mode_oh, NH);
    tick(); tick();
    chk("R10 flag sticky", tmr_flag, 1);
    tmr_clr = 1; tmr_evt = 4'b0001; tick(); tmr_evt = '0; tmr_clr = 0;
    chk("R10 event wins over clear", tmr_flag, 1);
    tmr_clr = 1; tick(); tmr_clr = 0;
    chk("R10 cleared by strobe", tmr_flag, 0);
    request(3'd2);
    chk("R5 sleep entered", mode_oh, SL);
    request(3'd1);
    chk("R5 request ignored in sleep", mode_oh, SL);
    tmr_evt = 4'b1000; tick(); tmr_evt = '0;
    tick(); tick(); tick();
    chk("R7 sleep before latency", mode_oh, SL);
    tick();
    chk("R7 sleep woke on flag", {mode_oh, wake_done}, {NH, 1'b1});
    tmr_clr = 1; tick(); tmr_clr = 0;
    pm_en = 0; request(3'd3);
    chk("R11 rejected with pm off", mode_oh, NH);
    pm_en = 1;
    request(3'd0); chk("R5 code 0 ignored", mode_oh, NH);
    request(3'd5); chk("R5 code 5 ignored", mode_oh, NH);
    request(3'd7); chk("R5 code 7 ignored", mode_oh, NH);
  endtask

  task automatic t_doze();
    do_reset();
    request(3'd1);
    chk("R5 doze-high from high", mode_oh, DH);
    gear_en = 1; tick();
    chk("R3 doze gear-down", {mode_oh, gear_hi}, {DL, 1'b0});
    gear_en = 0; tick();
    chk("R6 doze-low up on gear off", mode_oh, DH);
    gear_en = 1; tick();
    tmr_evt = 4'b0010; tick(); tmr_evt = '0; tick();
    chk("R6 doze-low up on flag", mode_oh, DH);
    tmr_clr = 1; tick(); tmr_clr = 0; tick();
    chk("R3 doze drops again", mode_oh, DL);
    irq_pend = 1; tick(); tick(); tick();
    chk("R6 doze before latency", mode_oh, DL);
    tick();
    chk("R6 doze woke", {mode_oh, wake_done}, {NH, 1'b1});
    irq_pend = 0; tick();
    chk("R3 gear-down after doze wake", mode_oh, NL);
    request(3'd1);
    chk("R5 doze-low from low", mode_oh, DL);
  endtask

  task automatic t_deep();
    do_reset();
    dsl_cfg = 9'd10; request(3'd3);
    chk("R5 deep entered", mode_oh, DS);
    pm_en = 0; tick();
    repeat (9) tick();
    chk("R8 deep before latency", mode_oh, DS);
    tick();
    chk("R8 deep woke on pm off", {mode_oh, wake_done}, {NH, 1'b1});
    pm_en = 1; dsl_cfg = 9'd0; request(3'd3);
    irq_pend = 1; tick();
    chk("R8 zero counts as one: still deep", mode_oh, DS);
    tick();
    chk("R8 zero latency woke", mode_oh, NH);
    irq_pend = 0; dsl_cfg = 9'd511; request(3'd3);
    irq_pend = 1; tick(); irq_pend = 0;
    repeat (498) tick();
    chk("R8 clamp before 499", mode_oh, DS);
    tick();
    chk("R8 clamp woke at 499", {mode_oh, wake_done}, {NH, 1'b1});
  endtask

  task automatic t_pdown();
    do_reset();
    request(3'd4);
    chk("R5 power-down entered", {mode_oh, pwr_req}, {PD, 1'b0});
    pwr_good = 1; irq_pend = 1; tick(); tick();
    chk("R9 irq and ack ignored", {mode_oh, pwr_req, por_req}, {PD, 2'b00});
    pwr_good = 0; irq_pend = 0; ext_wake = 1; tick(); ext_wake = 0;
    chk("R9 supply request", {mode_oh, pwr_req}, {PD, 1'b1});
    tick();
    chk("R9 waiting for ack", {mode_oh, pwr_req}, {PD, 1'b1});
    pwr_good = 1; tick(); pwr_good = 0;
    chk("R9 exit to high", mode_oh, NH);
    chk("R9 por and done", {por_req, wake_done, pwr_req}, 3'b110);
    tick();
    chk("R9 por one cycle", por_req, 0);
  endtask

  initial begin
    t_reset();
    t_gear_and_nl_wake();
    t_flag_and_reject();
    t_doze();
    t_deep();
    t_pdown();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    wait (cyc >= 20000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule